// File: doc/BRIEF.md
# Serial Flash Clock Divider with Scrambled Ratio Code

This block derives the serial flash clock from the bus clock. The control word holds a 4-bit divisor code. The code is not binary: each divisor from 1 to 16 has its own fixed code value. Depending on the build-time flavor, the ratio can be stretched in one of two ways. The prescale flavor adds a fixed divide-by-4 stage. The extended flavor adds a base field that contributes sixteen bus cycles per step.

The generator only picks up a new setting when the current output period ends, at which point the output is low. It also stops only at the end of a period, so no output pulse is ever cut short. Alongside the output clock it drives two single-cycle strobes that mark the start of each high phase and each low phase. The shift logic next to it can use these to align data.

A rate helper runs next to the generator. It takes the bus clock frequency and a maximum serial frequency, and returns the smallest allowed ratio whose output does not exceed that maximum. It also returns the control word that selects this ratio, and a hit flag. Software can copy the suggested word straight into the control input.

Top module: `sclk_divider`

## Requirements
- R1: The divisor code sits in control bits [11:8]. Divisors 1, 2, 3 … 16 are selected by codes 15, 7, 14, 6, 13, 5, 12, 4, 11, 3, 10, 2, 9, 1, 8, 0, in that order.
- R2: In the extended flavor, bits [27:24] hold a base value b. The output period is d + 16·b bus cycles, where d is the divisor decoded from bits [11:8].
- R3: In the prescale flavor, setting bit 13 makes the period 4·d bus cycles. With bit 13 clear, the period is d.
- R4: For a period of R ≥ 2 cycles, sclk is high for floor(R/2) bus cycles and then low for ceil(R/2) bus cycles. For R = 1, sclk follows the bus clock.
- R5: sclk_rise is high during the first bus cycle of every period. sclk_fall is high during the first low bus cycle of every period. For R = 1, both strobes are high in every cycle.
- R6: A new control word takes effect only at the end of the running period. The running period completes with its old phase lengths.
- R7: When en is raised while the clock is stopped, sclk goes high after the next rising bus clock edge. When en is dropped, the running period completes and sclk then stays low with no further rise strobe.
- R8: The helper returns the first candidate ratio R, in increasing order, for which floor(bus_hz / R) ≤ max_hz. The extended flavor's candidates are 2 to 240, taken as b = 0..14 with each d = 1..16, never b = 0 with d = 1. The prescale flavor tries 1 to 16 without prescale, then 4·1 to 4·16 with bit 13 set. The plain flavor tries 1 to 16.
- R9: The helper's outputs are registered and reflect bus_hz and max_hz one rising edge after they are applied. When no candidate fits, sugg_hit is 0, sugg_ratio is 0, and sugg_ctrl holds the flavor's default word.
- R10: During reset, sclk and both strobes are low and sugg_hit is 0. sugg_ctrl holds the default word: 0x0000_0400 in the extended flavor and 0 in the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request for the serial clock |
| ctrl_word | input | 32 | Divider control word (code, prescale bit, base field) |
| bus_hz | input | FREQ_W | Bus clock frequency for the helper |
| max_hz | input | FREQ_W | Highest allowed serial frequency for the helper |
| sclk | output | 1 | Serial flash clock |
| sclk_rise | output | 1 | Strobe for the first bus cycle of a period |
| sclk_fall | output | 1 | Strobe for the first low bus cycle of a period |
| sugg_ctrl | output | 32 | Control word suggested by the helper |
| sugg_ratio | output | RATIO_W | Ratio selected by the helper, 0 when none fits |
| sugg_hit | output | 1 | Helper found a fitting ratio |

## Verification
When the generator is idle, a setting applied before a rising edge shows up on sclk and sclk_rise just after that edge. A setting applied mid-period only shows up after the last low cycle of the running period. The helper's results arrive one rising edge after bus_hz and max_hz change. The bench drives every input on a falling edge and samples outputs on later falling edges, so each expected value is compared in the half cycle where it is due. For a ratio of 1, it samples once with the bus clock high and once with it low.

// File: rtl/sclkdiv_pkg.sv
`timescale 1ns/1ps
package sclkdiv_pkg;
  localparam int unsigned FLAVOR_PLAIN = 0;
  localparam int unsigned FLAVOR_PRE4  = 1;
  localparam int unsigned FLAVOR_EXT   = 2;

  localparam int unsigned CODE_LSB = 8;
  localparam int unsigned PRE4_BIT = 13;
  localparam int unsigned BASE_LSB = 24;

  // scrambled code -> divisor 1..16
  function automatic logic [4:0] code_to_div(input logic [3:0] c);
    int unsigned k;
    k = c;
    if (c[3]) return 5'(2 * (15 - k) + 1);
    else      return 5'(2 * (7 - k) + 2);
  endfunction

  // divisor 1..16 -> scrambled code
  function automatic logic [3:0] div_to_code(input logic [4:0] d);
    int unsigned k;
    k = d;
    if (d[0]) return 4'(15 - (k - 1) / 2);
    else      return 4'(7 - (k - 2) / 2);
  endfunction

  function automatic logic [31:0] default_word(input int unsigned flavor);
    return (flavor == FLAVOR_EXT) ? 32'h0000_0400 : 32'h0;
  endfunction

  function automatic int unsigned top_ratio(input int unsigned flavor);
    if (flavor == FLAVOR_EXT)  return 256;
    if (flavor == FLAVOR_PRE4) return 64;
    return 16;
  endfunction
endpackage

// File: rtl/sclkdiv_ratio_decode.sv
`timescale 1ns/1ps
module sclkdiv_ratio_decode
  import sclkdiv_pkg::*;
#(
  parameter int unsigned FLAVOR  = FLAVOR_EXT,
  parameter int unsigned RATIO_W = 9
) (
  input  logic [31:0]        ctrl,
  output logic [RATIO_W-1:0] ratio
);
  logic [4:0] div;
  assign div = code_to_div(ctrl[CODE_LSB +: 4]);

  generate
    if (FLAVOR == FLAVOR_EXT) begin : g_ext
      assign ratio = RATIO_W'(div) + (RATIO_W'(ctrl[BASE_LSB +: 4]) << 4);
    end else if (FLAVOR == FLAVOR_PRE4) begin : g_pre4
      assign ratio = ctrl[PRE4_BIT] ? (RATIO_W'(div) << 2) : RATIO_W'(div);
    end else begin : g_plain
      assign ratio = RATIO_W'(div);
    end
  endgenerate

  wire unused_ctrl = ^ctrl;
endmodule

// File: rtl/sclkdiv_rate_search.sv
`timescale 1ns/1ps
module sclkdiv_rate_search
  import sclkdiv_pkg::*;
#(
  parameter int unsigned FLAVOR  = FLAVOR_EXT,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned RATIO_W = 9
) (
  input  logic [FREQ_W-1:0]  bus_hz,
  input  logic [FREQ_W-1:0]  max_hz,
  output logic               hit,
  output logic [RATIO_W-1:0] ratio,
  output logic [31:0]        ctrl
);
  localparam int unsigned PW = FREQ_W + 10;

  // floor(bus/r) <= max  <=>  bus < (max+1)*r
  function automatic logic fits(input logic [FREQ_W-1:0] b,
                                input logic [FREQ_W-1:0] m,
                                input int unsigned r);
    logic [PW-1:0] prod;
    prod = (PW'(m) + PW'(1)) * PW'(r);
    return PW'(b) < prod;
  endfunction

  always_comb begin
    hit   = 1'b0;
    ratio = '0;
    ctrl  = default_word(FLAVOR);
    if (FLAVOR == FLAVOR_EXT) begin
      for (int j = 0; j < 15; j++) begin
        for (int i = 0; i < 16; i++) begin
          if (!hit && (i + j) != 0 && fits(bus_hz, max_hz, i + 1 + 16 * j)) begin
            hit   = 1'b1;
            ratio = RATIO_W'(i + 1 + 16 * j);
            ctrl  = '0;
            ctrl[CODE_LSB +: 4] = div_to_code(5'(i + 1));
            ctrl[BASE_LSB +: 4] = 4'(j);
          end
        end
      end
    end else begin
      for (int d = 1; d <= 16; d++) begin
        if (!hit && fits(bus_hz, max_hz, d)) begin
          hit   = 1'b1;
          ratio = RATIO_W'(d);
          ctrl  = '0;
          ctrl[CODE_LSB +: 4] = div_to_code(5'(d));
        end
      end
      if (FLAVOR == FLAVOR_PRE4) begin
        for (int n = 1; n <= 16; n++) begin
          if (!hit && fits(bus_hz, max_hz, 4 * n)) begin
            hit   = 1'b1;
            ratio = RATIO_W'(4 * n);
            ctrl  = '0;
            ctrl[CODE_LSB +: 4] = div_to_code(5'(n));
            ctrl[PRE4_BIT]      = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sclkdiv_phase_gen.sv
`timescale 1ns/1ps
module sclkdiv_phase_gen #(
  parameter int unsigned RATIO_W     = 9,
  parameter int unsigned RESET_RATIO = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RATIO_W-1:0] new_ratio,
  output logic               sclk,
  output logic               rise_stb,
  output logic               fall_stb
);
  logic [RATIO_W-1:0] act_ratio, cnt, cnt_nx, hi_act, hi_new;
  logic               running, sclk_q, load;

  assign hi_act = act_ratio >> 1;
  assign hi_new = new_ratio >> 1;
  assign cnt_nx = cnt + 1'b1;
  // period boundary: idle, or last (low) cycle of the running period
  assign load   = !running || (cnt == act_ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ratio <= RATIO_W'(RESET_RATIO);
      cnt       <= '0;
      running   <= 1'b0;
      sclk_q    <= 1'b0;
      rise_stb  <= 1'b0;
      fall_stb  <= 1'b0;
    end else if (load) begin
      act_ratio <= new_ratio;
      cnt       <= '0;
      running   <= en;
      sclk_q    <= en && (hi_new != '0);
      rise_stb  <= en;
      fall_stb  <= en && (new_ratio == RATIO_W'(1));
    end else begin
      cnt       <= cnt_nx;
      sclk_q    <= cnt_nx < hi_act;
      rise_stb  <= 1'b0;
      fall_stb  <= cnt_nx == hi_act;
    end
  end

  assign sclk = (running && act_ratio == RATIO_W'(1)) ? clk : sclk_q;

  AST_LOAD_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ratio != $past(act_ratio)) |-> !$past(sclk_q)); // R6
  AST_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> rise_stb); // R5
  AST_FALL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> fall_stb); // R5
  AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < act_ratio)); // R4
endmodule

// File: rtl/sclk_divider.sv
`timescale 1ns/1ps
module sclk_divider
  import sclkdiv_pkg::*;
#(
  parameter int unsigned FLAVOR = FLAVOR_EXT,
  parameter int unsigned FREQ_W = 32,
  localparam int unsigned RATIO_W = $clog2(top_ratio(FLAVOR) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [31:0]        ctrl_word,
  input  logic [FREQ_W-1:0]  bus_hz,
  input  logic [FREQ_W-1:0]  max_hz,
  output logic               sclk,
  output logic               sclk_rise,
  output logic               sclk_fall,
  output logic [31:0]        sugg_ctrl,
  output logic [RATIO_W-1:0] sugg_ratio,
  output logic               sugg_hit
);
  localparam logic [31:0] DEF_WORD  = default_word(FLAVOR);
  localparam int unsigned RST_RATIO = int'(code_to_div(DEF_WORD[CODE_LSB +: 4]));

  logic [RATIO_W-1:0] cfg_ratio, srch_ratio, chk_ratio;
  logic [31:0]        srch_ctrl;
  logic               srch_hit;

  sclkdiv_ratio_decode #(.FLAVOR(FLAVOR), .RATIO_W(RATIO_W)) u_cfg_decode (
    .ctrl(ctrl_word), .ratio(cfg_ratio));

  sclkdiv_phase_gen #(.RATIO_W(RATIO_W), .RESET_RATIO(RST_RATIO)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .new_ratio(cfg_ratio),
    .sclk(sclk), .rise_stb(sclk_rise), .fall_stb(sclk_fall));

  sclkdiv_rate_search #(.FLAVOR(FLAVOR), .FREQ_W(FREQ_W), .RATIO_W(RATIO_W)) u_search (
    .bus_hz(bus_hz), .max_hz(max_hz), .hit(srch_hit), .ratio(srch_ratio),
    .ctrl(srch_ctrl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sugg_ctrl  <= DEF_WORD;
      sugg_ratio <= '0;
      sugg_hit   <= 1'b0;
    end else begin
      sugg_ctrl  <= srch_ctrl;
      sugg_ratio <= srch_ratio;
      sugg_hit   <= srch_hit;
    end
  end

  // independent decode of the suggested word, for checking only
  sclkdiv_ratio_decode #(.FLAVOR(FLAVOR), .RATIO_W(RATIO_W)) u_chk_decode (
    .ctrl(sugg_ctrl), .ratio(chk_ratio));

  AST_SUGG_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    sugg_hit |-> (chk_ratio == sugg_ratio)); // R1
  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !sugg_hit |-> (sugg_ctrl == DEF_WORD && sugg_ratio == '0)); // R9

  generate
    if (FLAVOR == FLAVOR_EXT) begin : g_ext_chk
      AST_NO_UNIT_BASE0: assert property (@(posedge clk) disable iff (!rst_n)
        sugg_hit |-> !(sugg_ctrl[BASE_LSB +: 4] == 4'd0 &&
                       sugg_ctrl[CODE_LSB +: 4] == 4'd15)); // R8
    end
  endgenerate
endmodule

// File: tb/sclk_divider_bench.sv
`timescale 1ns/1ps
module sclk_divider_bench;
  import sclkdiv_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        en_a = 1'b0, en_b = 1'b0;
  logic [31:0] ctrl_a = '0, ctrl_b = '0, bus_hz = '0, max_hz = '0;
  logic        sclk_a, rise_a, fall_a, hit_a, sclk_b, rise_b, fall_b, hit_b;
  logic [31:0] sctl_a, sctl_b;
  logic [8:0]  srat_a;
  logic [6:0]  srat_b;

  sclk_divider #(.FLAVOR(FLAVOR_EXT), .FREQ_W(32)) u_sclk_divider (
    .clk(clk), .rst_n(rst_n), .en(en_a), .ctrl_word(ctrl_a),
    .bus_hz(bus_hz), .max_hz(max_hz), .sclk(sclk_a), .sclk_rise(rise_a),
    .sclk_fall(fall_a), .sugg_ctrl(sctl_a), .sugg_ratio(srat_a), .sugg_hit(hit_a));

  sclk_divider #(.FLAVOR(FLAVOR_PRE4), .FREQ_W(32)) u_sclk_divider_pre4 (
    .clk(clk), .rst_n(rst_n), .en(en_b), .ctrl_word(ctrl_b),
    .bus_hz(bus_hz), .max_hz(max_hz), .sclk(sclk_b), .sclk_rise(rise_b),
    .sclk_fall(fall_b), .sugg_ctrl(sctl_b), .sugg_ratio(srat_b), .sugg_hit(hit_b));

  int checks = 0, errors = 0, cycles = 0;
  always @(posedge clk) cycles++;

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R1 code table
  function automatic logic [31:0] enc(input int d);
    case (d)
      1: return 15;  2: return 7;   3: return 14;  4: return 6;
      5: return 13;  6: return 5;   7: return 12;  8: return 4;
      9: return 11;  10: return 3;  11: return 10; 12: return 2;
      13: return 9;  14: return 1;  15: return 8;  default: return 0;
    endcase
  endfunction

  function automatic logic s_sclk(input bit b); return b ? sclk_b : sclk_a; endfunction
  function automatic logic s_rise(input bit b); return b ? rise_b : rise_a; endfunction
  function automatic logic s_fall(input bit b); return b ? fall_b : fall_a; endfunction

  // waits for the next period start, then measures one full period
  task automatic period_check(input bit b, input int r, input string tag);
    int guard = 0, h = 0, l = 0;
    do begin @(negedge clk); guard++; end while (!s_rise(b) && guard < 1000);
    check_eq({tag, " rise strobe"}, s_rise(b), 1);
    while (s_sclk(b) && h < 1000) begin h++; @(negedge clk); end
    check_eq({tag, " high cycles"}, h, r / 2);
    check_eq({tag, " fall strobe"}, s_fall(b), 1);
    while (!s_rise(b) && !s_sclk(b) && l < 1000) begin l++; @(negedge clk); end
    check_eq({tag, " low cycles"}, l, r - r / 2);
  endtask

  task automatic search_check(input string tag);
    bit hit = 0; int rr = 0; logic [31:0] c = 32'h400;
    for (int r = 2; r <= 240 && !hit; r++)
      if (longint'(bus_hz) / r <= longint'(max_hz)) begin
        hit = 1; rr = r;
        c = (enc((r - 1) % 16 + 1) << 8) | (32'((r - 1) / 16) << 24);
      end
    check_eq({tag, " R8 ext ctrl"}, sctl_a, c);
    check_eq({tag, " R8 ext ratio"}, srat_a, rr);
    check_eq({tag, " R9 ext hit"}, hit_a, hit);
    hit = 0; rr = 0; c = 32'h0;
    for (int r = 1; r <= 16 && !hit; r++)
      if (longint'(bus_hz) / r <= longint'(max_hz)) begin
        hit = 1; rr = r; c = enc(r) << 8;
      end
    for (int n = 1; n <= 16 && !hit; n++)
      if (longint'(bus_hz) / (4 * n) <= longint'(max_hz)) begin
        hit = 1; rr = 4 * n; c = (32'h1 << 13) | (enc(n) << 8);
      end
    check_eq({tag, " R8 pre4 ctrl"}, sctl_b, c);
    check_eq({tag, " R8 pre4 ratio"}, srat_b, rr);
    check_eq({tag, " R9 pre4 hit"}, hit_b, hit);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end

  initial begin
    int h, l, bad;
    // R10 reset state
    repeat (3) @(negedge clk);
    check_eq("R10 sclk", sclk_a | sclk_b, 0);
    check_eq("R10 strobes", rise_a | fall_a | rise_b | fall_b, 0);
    check_eq("R10 ext default word", sctl_a, 32'h400);
    check_eq("R10 pre4 default word", sctl_b, 0);
    check_eq("R10 hit", hit_a | hit_b, 0);
    rst_n = 1'b1;

    // R7 start latency from idle
    @(negedge clk);
    ctrl_a = enc(5) << 8; en_a = 1'b1;
    @(negedge clk);
    check_eq("R7 start sclk", sclk_a, 1);
    check_eq("R7 start rise", rise_a, 1);
    period_check(0, 5, "R4 ext d5");

    // R1 R2 sweep on extended flavor
    for (int b = 0; b < 2; b++)
      for (int d = 1; d <= 16; d++) begin
        if (b == 0 && d == 1) continue;
        ctrl_a = (enc(d) << 8) | (32'(b) << 24);
        period_check(0, d + 16 * b, $sformatf("R1 R2 d%0d b%0d", d, b));
      end
    ctrl_a = (enc(16) << 8) | (32'd15 << 24);
    period_check(0, 256, "R2 top ratio");

    // R6 change in mid period
    ctrl_a = enc(8) << 8;
    period_check(0, 8, "R6 setup");
    ctrl_a = enc(3) << 8;
    h = 1; l = 0;
    @(negedge clk);
    while (sclk_a && h < 100) begin h++; @(negedge clk); end
    while (!sclk_a && !rise_a && l < 100) begin l++; @(negedge clk); end
    check_eq("R6 old high kept", h, 4);
    check_eq("R6 old low kept", l, 4);
    period_check(0, 3, "R6 new ratio");

    // R7 stop completes the period
    ctrl_a = enc(6) << 8;
    period_check(0, 6, "R7 setup");
    en_a = 1'b0;
    h = 1; bad = 0;
    @(negedge clk);
    while (sclk_a && h < 100) begin h++; @(negedge clk); end
    check_eq("R7 last high", h, 3);
    for (int k = 0; k < 40; k++) begin
      if (sclk_a || rise_a) bad++;
      @(negedge clk);
    end
    check_eq("R7 stays low", bad, 0);

    // R4 R5 ratio one follows bus clock
    ctrl_a = enc(1) << 8; en_a = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1.25;
      check_eq("R4 unit ratio high", sclk_a, 1);
      @(negedge clk); #0.5;
      check_eq("R4 unit ratio low", sclk_a, 0);
      check_eq("R5 unit strobes", rise_a & fall_a, 1);
    end
    en_a = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk); #1.25;
    check_eq("R7 unit ratio stopped", sclk_a, 0);

    // R3 prescale flavor
    @(negedge clk);
    ctrl_b = (32'h1 << 13) | (enc(1) << 8); en_b = 1'b1;
    for (int d = 1; d <= 16; d++) begin
      ctrl_b = (32'h1 << 13) | (enc(d) << 8);
      period_check(1, 4 * d, $sformatf("R3 pre4 d%0d", d));
    end
    ctrl_b = enc(2) << 8;  period_check(1, 2, "R3 plain d2");
    ctrl_b = enc(7) << 8;  period_check(1, 7, "R3 plain d7");
    ctrl_b = enc(16) << 8; period_check(1, 16, "R3 plain d16");
    en_b = 1'b0;

    // R8 R9 helper sweep
    @(negedge clk);
    bus_hz = 1000;
    for (int m = 0; m <= 1000; m++) begin
      max_hz = m;
      @(negedge clk);
      search_check($sformatf("bus1000 max%0d", m));
    end
    bus_hz = 200_000_000;
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: max_hz = 200_000_000;
        1: max_hz = 100_000_000;
        2: max_hz = 50_000_000;
        3: max_hz = 33_000_000;
        4: max_hz = 1_000_000;
        default: max_hz = 0;
      endcase
      @(negedge clk);
      search_check($sformatf("bus200M case%0d", k));
    end
    bus_hz = 32'hFFFF_FFFF; max_hz = 1;
    @(negedge clk);
    search_check("no fit");

    finish_run();
  end
endmodule